// File: doc/BRIEF.md
# Speculative Load Violation Table

This block keeps watch over loads that were allowed to issue ahead of older stores. When such a load issues, it takes an entry that records three things: the word address it read, the bytes it read within that word, and its own reorder-buffer ID. The entry also records where the load got its data. That is either the ID of the store that forwarded the value, or a reserved "from memory" code that lies outside the reorder-buffer index range. Stores may execute in any order. The table only looks at a store when that store retires. At that point it compares the store's address against every live entry, and it updates a per-load violation flag in each entry that matches.

When a load retires, the load-retire port looks up that load's entry. If the flag is set, the block raises a rollback request so that fetch restarts at that load. In both cases the entry is released. A flush port drops every entry belonging to a load younger than the flush point. Age is measured from the current reorder-buffer head, so the ID wraps around.

Each entry is a small state machine with three states:
- `SLT_FREE`: unused.
- `SLT_CLEAN`: live, no violation.
- `SLT_VIOL`: live, violation pending.

It moves between them on five events:
- *allocate*: FREE to CLEAN.
- *foreign hit*: CLEAN to VIOL, when a matching store is not the producer.
- *producer hit*: VIOL to CLEAN, when the matching store is the producer.
- *retire*: CLEAN or VIOL to FREE.
- *flush kill*: CLEAN or VIOL to FREE.

A matching store on an entry that is already in the target state leaves it there.

Top module: `slt_table`

## Requirements
- R1: An accepted allocate (`alloc_valid` high while `alloc_ready` is high) takes a free entry. A later retire of that load ID with no intervening matching store gives `ret_rollback` low and releases the entry.
- R2: A producer field equal to the reserved code `{1'b1, 0...}` (bit ID_W set) marks data from memory. Any matching retiring store then sets the violation flag, because no store ID can equal the reserved code.
- R3: A retiring store that matches an entry and has an ID different from the entry's producer sets that entry's violation flag.
- R4: A retiring store that matches an entry and has an ID equal to the entry's producer (`{1'b0, st_id}`) clears that entry's violation flag.
- R5: A store matches an entry only when the word addresses are equal and the byte masks (bit i = byte i of the word) share at least one set bit. A partial overlap counts as a match. A different word, or disjoint masks, has no effect.
- R6: A single retiring store updates every matching entry in the same cycle.
- R7: When `ret_valid` names the ID of a live entry, `ret_rollback` is combinationally high exactly when that entry's flag is set. The entry is released either way.
- R8: A retire with an ID held by no live entry gives `ret_rollback` low and changes no entry.
- R9: When all ENTRIES entries are live, `alloc_ready` is low and an offered allocate is ignored.
- R10: A flush releases every entry whose age `(load_id - rob_head) mod 2^ID_W` is greater than the flush point's age. Older entries and the flush-point entry itself stay. `alloc_ready` is low during a flush cycle.
- R11: When a store retire and a load retire fall in the same cycle, the load's rollback decision includes that store's effect. An entry allocated in that cycle is not affected by that store.
- R12: After reset every entry is free, `alloc_ready` is high and `ret_rollback` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rob_head | input | ID_W | Reorder-buffer ID of the oldest instruction, used for age |
| alloc_valid | input | 1 | A load wants to issue speculatively |
| alloc_ready | output | 1 | A free entry exists and no flush is in progress |
| alloc_addr | input | WADDR_W | Word address read by the load |
| alloc_mask | input | BYTES | Bytes read within that word |
| alloc_lid | input | ID_W | Load's reorder-buffer ID |
| alloc_pid | input | ID_W+1 | Producer store ID, or the reserved code when the data came from memory |
| st_valid | input | 1 | A store is retiring |
| st_addr | input | WADDR_W | Word address written by the store |
| st_mask | input | BYTES | Bytes written |
| st_id | input | ID_W | Store's reorder-buffer ID |
| ret_valid | input | 1 | A load is retiring |
| ret_lid | input | ID_W | ID of the retiring load |
| ret_rollback | output | 1 | Restart fetch at the retiring load |
| flush_valid | input | 1 | Drop entries younger than the flush point |
| flush_lid | input | ID_W | ID of the flush point |

## Verification
Three functions can fall in the same cycle. A store probe and a load retire can coincide; so can a store probe and an allocate. The bench drives both pairs in the same cycle. In one case a memory-sourced load is retired in the very cycle a matching store retires, and a rollback must appear even though the flag had been clear. In the other case a load is allocated alongside a matching store and must later retire clean. A behavioural queue model applies the probe before the retire and the allocate after both, and it is compared with both outputs every cycle.

// File: rtl/slt_pkg.sv
package slt_pkg;

    // Life cycle of one table entry.
    typedef enum logic [1:0] {
        SLT_FREE  = 2'd0,
        SLT_CLEAN = 2'd1,
        SLT_VIOL  = 2'd2
    } slt_state_e;

endpackage

// File: rtl/slt_entry.sv
module slt_entry
    import slt_pkg::*;
#(
    parameter int WADDR_W = 30,
    parameter int BYTES   = 4,
    parameter int ID_W    = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ID_W-1:0]    rob_head,
    input  logic               alloc_we,
    input  logic [WADDR_W-1:0] alloc_addr,
    input  logic [BYTES-1:0]   alloc_mask,
    input  logic [ID_W-1:0]    alloc_lid,
    input  logic [ID_W:0]      alloc_pid,
    input  logic               st_valid,
    input  logic [WADDR_W-1:0] st_addr,
    input  logic [BYTES-1:0]   st_mask,
    input  logic [ID_W-1:0]    st_id,
    input  logic               ret_valid,
    input  logic [ID_W-1:0]    ret_lid,
    input  logic               flush_valid,
    input  logic [ID_W-1:0]    flush_lid,
    output logic               busy,
    output logic               ret_hit,
    output logic               viol_after
);

    slt_state_e         state_q, state_d;
    logic [WADDR_W-1:0] addr_q;
    logic [BYTES-1:0]   mask_q;
    logic [ID_W-1:0]    lid_q;
    logic [ID_W:0]      pid_q;
    logic               st_hit;
    logic               kill;
    logic [ID_W-1:0]    age_own;
    logic [ID_W-1:0]    age_flush;

    // State register and captured fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLT_FREE;
        end else begin
            state_q <= state_d;
        end
        if (alloc_we) begin
            addr_q <= alloc_addr;
            mask_q <= alloc_mask;
            lid_q  <= alloc_lid;
            pid_q  <= alloc_pid;
        end
    end

    // Outputs and event decode.
    always_comb begin
        busy      = (state_q != SLT_FREE);
        st_hit    = st_valid && busy && (addr_q == st_addr) && ((mask_q & st_mask) != '0);
        ret_hit   = ret_valid && busy && (lid_q == ret_lid);
        age_own   = lid_q - rob_head;
        age_flush = flush_lid - rob_head;
        kill      = flush_valid && busy && (age_own > age_flush);
        if (st_hit) begin
            viol_after = (pid_q != {1'b0, st_id});
        end else begin
            viol_after = (state_q == SLT_VIOL);
        end
    end

    // Next state.
    always_comb begin
        unique case (state_q)
            SLT_FREE: begin
                state_d = alloc_we ? SLT_CLEAN : SLT_FREE;
            end
            SLT_CLEAN, SLT_VIOL: begin
                if (ret_hit || kill) begin
                    state_d = SLT_FREE;
                end else begin
                    state_d = viol_after ? SLT_VIOL : SLT_CLEAN;
                end
            end
            default: state_d = SLT_FREE;
        endcase
    end

endmodule

// File: rtl/slt_pick.sv
module slt_pick #(
    parameter int ENTRIES = 8
) (
    input  logic [ENTRIES-1:0] free_vec,
    output logic [ENTRIES-1:0] grant,
    output logic               any_free
);

    always_comb begin
        logic found;
        found = 1'b0;
        grant = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (free_vec[i] && !found) begin
                grant[i] = 1'b1;
                found    = 1'b1;
            end
        end
        any_free = found;
    end

endmodule

// File: rtl/slt_table.sv
module slt_table #(
    parameter int ENTRIES = 8,
    parameter int WADDR_W = 30,
    parameter int BYTES   = 4,
    parameter int ID_W    = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ID_W-1:0]    rob_head,
    input  logic               alloc_valid,
    output logic               alloc_ready,
    input  logic [WADDR_W-1:0] alloc_addr,
    input  logic [BYTES-1:0]   alloc_mask,
    input  logic [ID_W-1:0]    alloc_lid,
    input  logic [ID_W:0]      alloc_pid,
    input  logic               st_valid,
    input  logic [WADDR_W-1:0] st_addr,
    input  logic [BYTES-1:0]   st_mask,
    input  logic [ID_W-1:0]    st_id,
    input  logic               ret_valid,
    input  logic [ID_W-1:0]    ret_lid,
    output logic               ret_rollback,
    input  logic               flush_valid,
    input  logic [ID_W-1:0]    flush_lid
);

    logic [ENTRIES-1:0] busy_vec;
    logic [ENTRIES-1:0] ret_hit_vec;
    logic [ENTRIES-1:0] viol_vec;
    logic [ENTRIES-1:0] grant;
    logic [ENTRIES-1:0] alloc_we;
    logic               any_free;
    logic               alloc_fire;

    slt_pick #(.ENTRIES(ENTRIES)) u_pick (
        .free_vec (~busy_vec),
        .grant    (grant),
        .any_free (any_free)
    );

    always_comb begin
        alloc_ready  = any_free && !flush_valid;
        alloc_fire   = alloc_valid && alloc_ready;
        alloc_we     = alloc_fire ? grant : '0;
        ret_rollback = |(ret_hit_vec & viol_vec);
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        slt_entry #(
            .WADDR_W (WADDR_W),
            .BYTES   (BYTES),
            .ID_W    (ID_W)
        ) u_ent (
            .clk         (clk),
            .rst_n       (rst_n),
            .rob_head    (rob_head),
            .alloc_we    (alloc_we[g]),
            .alloc_addr  (alloc_addr),
            .alloc_mask  (alloc_mask),
            .alloc_lid   (alloc_lid),
            .alloc_pid   (alloc_pid),
            .st_valid    (st_valid),
            .st_addr     (st_addr),
            .st_mask     (st_mask),
            .st_id       (st_id),
            .ret_valid   (ret_valid),
            .ret_lid     (ret_lid),
            .flush_valid (flush_valid),
            .flush_lid   (flush_lid),
            .busy        (busy_vec[g]),
            .ret_hit     (ret_hit_vec[g]),
            .viol_after  (viol_vec[g])
        );
    end

endmodule

// File: rtl/slt_table_chk.sv
module slt_table_chk #(
    parameter int ENTRIES = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               alloc_valid,
    input logic               alloc_ready,
    input logic               ret_valid,
    input logic               ret_rollback,
    input logic               flush_valid,
    input logic [ENTRIES-1:0] busy_vec
);

    a_r1_alloc_takes_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && alloc_ready && !ret_valid && !flush_valid)
        |=> ($countones(busy_vec) == $past($countones(busy_vec)) + 1));

    a_r7_rollback_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_rollback && !alloc_valid && !flush_valid)
        |=> ($countones(busy_vec) + 1 == $past($countones(busy_vec))));

    a_r8_rollback_needs_retire: assert property (@(posedge clk) disable iff (!rst_n)
        ret_rollback |-> ret_valid);

    a_r9_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(busy_vec) == ENTRIES) |-> !alloc_ready);

    a_r10_flush_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |=> ($countones(busy_vec) <= $past($countones(busy_vec))));

endmodule

bind slt_table slt_table_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .alloc_valid  (alloc_valid),
    .alloc_ready  (alloc_ready),
    .ret_valid    (ret_valid),
    .ret_rollback (ret_rollback),
    .flush_valid  (flush_valid),
    .busy_vec     (busy_vec)
);

// File: tb/slt_table_tb.sv
module slt_table_tb;

    localparam int N    = 8;
    localparam int AW   = 30;
    localparam int BY   = 4;
    localparam int IW   = 6;
    localparam logic [IW:0] MEMSRC = 7'h40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [IW-1:0] rob_head = '0;
    logic          alloc_valid = 1'b0;
    logic          alloc_ready;
    logic [AW-1:0] alloc_addr = '0;
    logic [BY-1:0] alloc_mask = '0;
    logic [IW-1:0] alloc_lid = '0;
    logic [IW:0]   alloc_pid = '0;
    logic          st_valid = 1'b0;
    logic [AW-1:0] st_addr = '0;
    logic [BY-1:0] st_mask = '0;
    logic [IW-1:0] st_id = '0;
    logic          ret_valid = 1'b0;
    logic [IW-1:0] ret_lid = '0;
    logic          ret_rollback;
    logic          flush_valid = 1'b0;
    logic [IW-1:0] flush_lid = '0;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    slt_table #(.ENTRIES(N), .WADDR_W(AW), .BYTES(BY), .ID_W(IW)) u_dut (
        .clk(clk), .rst_n(rst_n), .rob_head(rob_head),
        .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
        .alloc_addr(alloc_addr), .alloc_mask(alloc_mask),
        .alloc_lid(alloc_lid), .alloc_pid(alloc_pid),
        .st_valid(st_valid), .st_addr(st_addr), .st_mask(st_mask), .st_id(st_id),
        .ret_valid(ret_valid), .ret_lid(ret_lid), .ret_rollback(ret_rollback),
        .flush_valid(flush_valid), .flush_lid(flush_lid)
    );

    // Behavioural reference: a queue of live loads.
    typedef struct {
        logic [AW-1:0] a;
        logic [BY-1:0] m;
        logic [IW-1:0] lid;
        logic [IW:0]   pid;
        bit            exc;
    } ent_t;
    ent_t mq[$];

    function automatic bit probe_hit(ent_t e);
        return st_valid && (e.a == st_addr) && ((e.m & st_mask) != '0);
    endfunction

    function automatic int age(logic [IW-1:0] id);
        return (int'(id) - int'(rob_head)) & ((1 << IW) - 1);
    endfunction

    task automatic check(string tag, string what, logic act, logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // One cycle: inputs are already driven; compare, then advance the model.
    task automatic step(string tag);
        bit exp_ready, exp_rb, fire;
        ent_t nq[$];
        #1;
        exp_ready = (mq.size() < N) && !flush_valid;
        exp_rb = 1'b0;
        foreach (mq[i]) begin
            if (ret_valid && mq[i].lid == ret_lid) begin
                exp_rb = probe_hit(mq[i]) ? (mq[i].pid != {1'b0, st_id}) : mq[i].exc;
            end
        end
        check(tag, "alloc_ready", alloc_ready, exp_ready);
        check(tag, "ret_rollback", ret_rollback, exp_rb);
        fire = alloc_valid && exp_ready;
        @(posedge clk);
        foreach (mq[i]) begin
            if (probe_hit(mq[i])) mq[i].exc = (mq[i].pid != {1'b0, st_id});
            if (!(ret_valid && mq[i].lid == ret_lid) &&
                !(flush_valid && age(mq[i].lid) > age(flush_lid)))
                nq.push_back(mq[i]);
        end
        if (fire) nq.push_back('{alloc_addr, alloc_mask, alloc_lid, alloc_pid, 1'b0});
        mq = nq;
        @(negedge clk);
        alloc_valid = 1'b0;
        st_valid    = 1'b0;
        ret_valid   = 1'b0;
        flush_valid = 1'b0;
    endtask

    task automatic set_alloc(int id, int a, int m, logic [IW:0] p);
        alloc_valid = 1'b1; alloc_lid = IW'(id); alloc_addr = AW'(a);
        alloc_mask = BY'(m); alloc_pid = p;
    endtask
    task automatic set_store(int id, int a, int m);
        st_valid = 1'b1; st_id = IW'(id); st_addr = AW'(a); st_mask = BY'(m);
    endtask
    task automatic set_ret(int id);
        ret_valid = 1'b1; ret_lid = IW'(id);
    endtask
    function automatic logic [IW:0] sid(int id);
        return {1'b0, IW'(id)};
    endfunction

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step("R12");

        // R1: clean allocate then retire
        set_alloc(5, 'h10, 'hf, MEMSRC); step("R1");
        set_ret(5); step("R1");

        // R3: foreign store sets the flag
        set_alloc(6, 'h11, 'hf, sid(2)); step("R3");
        set_store(3, 'h11, 'h1); step("R3");
        set_ret(6); step("R3");

        // R4: producer store clears a set flag
        set_alloc(7, 'h12, 'hf, sid(4)); step("R4");
        set_store(9, 'h12, 'hf); step("R4");
        set_store(4, 'h12, 'h2); step("R4");
        set_ret(7); step("R4");

        // R2: memory-sourced load hit by any store
        set_alloc(8, 'h13, 'hf, MEMSRC); step("R2");
        set_store(0, 'h13, 'h8); step("R2");
        set_ret(8); step("R2");

        // R5: disjoint masks / other word ignored, partial overlap matches
        set_alloc(10, 'h20, 'h3, MEMSRC); step("R5");
        set_store(1, 'h20, 'hc); step("R5");
        set_store(1, 'h21, 'hf); step("R5");
        set_ret(10); step("R5");
        set_alloc(11, 'h20, 'h6, MEMSRC); step("R5");
        set_store(1, 'h20, 'hc); step("R5");
        set_ret(11); step("R5");

        // R6: one store hits three entries
        set_alloc(20, 'h30, 'hf, sid(1)); step("R6");
        set_alloc(21, 'h30, 'h1, sid(2)); step("R6");
        set_alloc(22, 'h30, 'h8, MEMSRC); step("R6");
        set_store(7, 'h30, 'h9); step("R6");
        set_ret(20); step("R6");
        set_ret(21); step("R6");
        set_ret(22); step("R6");

        // R8: unknown ID
        set_alloc(23, 'h31, 'hf, MEMSRC); step("R8");
        set_store(2, 'h31, 'hf); step("R8");
        set_ret(24); step("R8");
        set_ret(23); step("R8");

        // R9: fill, offer while full, confirm the offered load is absent
        for (int k = 0; k < N; k++) begin
            set_alloc(30 + k, 'h40 + k, 'hf, MEMSRC); step("R9");
        end
        set_alloc(50, 'h50, 'hf, MEMSRC); step("R9");
        set_store(3, 'h50, 'hf); set_ret(50); step("R9");
        for (int k = 0; k < N; k++) begin
            set_ret(30 + k); step("R7");
        end

        // R10: flush drops younger loads only, blocks allocate
        set_alloc(2, 'h60, 'hf, MEMSRC); step("R10");
        set_alloc(4, 'h60, 'hf, MEMSRC); step("R10");
        set_alloc(6, 'h60, 'hf, MEMSRC); step("R10");
        flush_valid = 1'b1; flush_lid = 6'd4;
        set_alloc(9, 'h60, 'hf, MEMSRC); step("R10");
        set_store(1, 'h60, 'hf); step("R10");
        set_ret(2); step("R10");
        set_ret(4); step("R10");
        set_ret(6); step("R10");
        set_ret(9); step("R10");

        // R10 with wrap-around age
        rob_head = 6'd60;
        set_alloc(62, 'h61, 'hf, MEMSRC); step("R10");
        set_alloc(1, 'h61, 'hf, MEMSRC); step("R10");
        flush_valid = 1'b1; flush_lid = 6'd63; step("R10");
        set_store(5, 'h61, 'hf); step("R10");
        set_ret(1); step("R10");
        set_ret(62); step("R10");
        rob_head = 6'd0;

        // R11: store retire and load retire in one cycle
        set_alloc(12, 'h70, 'hf, MEMSRC); step("R11");
        set_store(3, 'h70, 'h4); set_ret(12); step("R11");
        // R11: allocate alongside a matching store stays clean
        set_alloc(13, 'h71, 'hf, MEMSRC); set_store(3, 'h71, 'hf); step("R11");
        set_ret(13); step("R11");
        // producer clears in the same cycle as retire
        set_alloc(14, 'h72, 'hf, sid(6)); step("R11");
        set_store(8, 'h72, 'hf); step("R11");
        set_store(6, 'h72, 'hf); set_ret(14); step("R11");

        step("R12");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule